// File: doc/BRIEF.md
# DMA Transfer Mode Selector

This block chooses the fastest DMA transfer mode that both a host controller and an attached storage device can use. The inputs are the host's per-family capability masks, the masks the device reports along with their validity flags, a legacy single-word timing number, a cable-detect flag and a ceiling mode that software asks for. The result is an 8-bit mode code. The value zero means DMA is not to be used.

The block has three mode families. Each family has a base code: Ultra is 0x40, multi-word is 0x20 and single-word is 0x10. A mode code is the family base plus the bit index of the mode inside that family. To run a selection, pulse `start` for one cycle while the inputs are stable. The block captures the result on that clock edge. In the next cycle it raises `done` for one cycle, and `mode` keeps its value until the next `start`.

Top module: `dma_mode_sel`

## Requirements
- R1: While `rst` is high, `done` is 0 and `mode` is 0x00 from the following edge on.
- R2: `done` is high in exactly the cycle that follows a cycle with `start` high. `mode` does not change unless `start` was high in the cycle before.
- R3: Families are tried in the order Ultra (base 0x40), then multi-word (base 0x20), then single-word (base 0x10). The first family with a nonzero effective mask wins. The chosen code is that family's base plus the index of the highest set bit of its mask.
- R4: A family is skipped when its base code is greater than `req_mode`.
- R5: The Ultra mask is `host_udma & dev_udma`. It is used only when `id_valid[2]` is 1; otherwise it is treated as zero.
- R6: The Ultra mask is reduced to its bits 0 to 2 when all three of these hold: `req_mode` is greater than 0x42, the mask has any of bits 3 to 6 set, and `cable80` is 0.
- R7: The multi-word mask is `host_mwdma & dev_mwdma`, and the single-word mask is `host_swdma & dev_swdma`. Both are used only when `id_valid[1]` is 1.
- R8: When `id_valid[1]` is 0 and `legacy_t` is 1 or 2, the single-word mask is `((2 << legacy_t) - 1) & host_swdma`. When `legacy_t` is 0 or greater than 2, the single-word mask is zero.
- R9: The output is the smaller of the chosen code and `req_mode`. If no family yields a mode, the output is 0x00.
- R10: When `is_disk` is 0 and `no_pkt_dma` is 1, the output is 0x00 whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Selection strobe; inputs are sampled on this edge |
| host_udma | input | UDMA_BITS | Host Ultra mode capability mask |
| host_mwdma | input | MW_BITS | Host multi-word mode capability mask |
| host_swdma | input | SW_BITS | Host single-word mode capability mask |
| dev_udma | input | UDMA_BITS | Device-reported Ultra mask |
| dev_mwdma | input | MW_BITS | Device-reported multi-word mask |
| dev_swdma | input | SW_BITS | Device-reported single-word mask |
| id_valid | input | 3 | Validity flags: bit 1 regular DMA fields, bit 2 Ultra field |
| legacy_t | input | 8 | Legacy single-word timing mode number |
| cable80 | input | 1 | 80-wire cable detected |
| req_mode | input | 8 | Requested ceiling mode code |
| is_disk | input | 1 | Device is a disk (0 = packet device) |
| no_pkt_dma | input | 1 | Host forbids DMA for packet devices |
| done | output | 1 | One-cycle result strobe |
| mode | output | 8 | Selected mode code, 0x00 for no DMA |

## Verification
The corner cases are the cable cap at the ceiling boundary, with requests of 0x42 and 0x43 and masks that do or do not reach bit 3, and the fall-through from an enabled Ultra family whose effective mask is zero. Further cases are a legacy timing value of 0 or 3, where a design that ignored the range check would report a single-word mode, and requests below 0x10 or inside a family, where a missing clamp would return a mode faster than the one asked for. A design that got the packet-device gate wrong would report a mode for a packet device that the host forbids. Ceiling values both between and inside family ranges show whether the skip rule and the clamp are ordered correctly.

// File: rtl/dms_pkg.sv
package dms_pkg;

    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] BASE_ULTRA = 8'h40;
    localparam logic [CODE_W-1:0] BASE_MULTI = 8'h20;
    localparam logic [CODE_W-1:0] BASE_SINGLE = 8'h10;

    // Ceiling above which the cable check applies (Ultra mode 2)
    localparam logic [CODE_W-1:0] CABLE_LIMIT = 8'h42;

    // Validity flag positions
    localparam int VLD_REGULAR = 1;
    localparam int VLD_ULTRA = 2;

    typedef enum logic [1:0] {
        FAM_NONE = 2'd0,
        FAM_ULTRA = 2'd1,
        FAM_MULTI = 2'd2,
        FAM_SINGLE = 2'd3
    } family_e;

    typedef struct packed {
        logic [7:0] ultra;
        logic [7:0] multi;
        logic [7:0] single;
    } fam_masks_t;

    // Index of the highest set bit (0 when vector is zero)
    function automatic logic [2:0] top_bit(input logic [7:0] v);
        logic [2:0] idx;
        idx = 3'd0;
        for (int i = 0; i < 8; i++) begin
            if (v[i]) idx = 3'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/dms_ultra_mask.sv
module dms_ultra_mask #(
    parameter int UDMA_BITS = 8
) (
    input  logic [UDMA_BITS-1:0] host_m,
    input  logic [UDMA_BITS-1:0] dev_m,
    input  logic                 valid,
    input  logic                 cable80,
    input  logic [7:0]           req_mode,
    output logic [7:0]           mask_o
);
    import dms_pkg::*;

    logic [7:0] raw;
    logic       fast_bits;
    logic       cap;

    always_comb begin
        raw = '0;
        if (valid) raw[UDMA_BITS-1:0] = host_m & dev_m;
    end

    assign fast_bits = |raw[6:3];
    assign cap = (req_mode > CABLE_LIMIT) && fast_bits && !cable80;
    assign mask_o = cap ? {5'b0, raw[2:0]} : raw;

endmodule

// File: rtl/dms_regular_mask.sv
module dms_regular_mask #(
    parameter int MW_BITS = 3,
    parameter int SW_BITS = 3
) (
    input  logic [MW_BITS-1:0] host_mw,
    input  logic [MW_BITS-1:0] dev_mw,
    input  logic [SW_BITS-1:0] host_sw,
    input  logic [SW_BITS-1:0] dev_sw,
    input  logic               valid,
    input  logic [7:0]         legacy_t,
    output logic [7:0]         mw_o,
    output logic [7:0]         sw_o
);
    localparam int LEGACY_MAX = 2;

    logic [7:0] legacy_m;
    logic       legacy_ok;

    assign legacy_ok = (legacy_t != 8'd0) && (legacy_t <= 8'(LEGACY_MAX));

    always_comb begin
        legacy_m = '0;
        if (legacy_ok) legacy_m = (8'd2 << legacy_t[1:0]) - 8'd1;
    end

    always_comb begin
        mw_o = '0;
        sw_o = '0;
        if (valid) begin
            mw_o[MW_BITS-1:0] = host_mw & dev_mw;
            sw_o[SW_BITS-1:0] = host_sw & dev_sw;
        end else begin
            sw_o[SW_BITS-1:0] = legacy_m[SW_BITS-1:0] & host_sw;
        end
    end

endmodule

// File: rtl/dms_pick.sv
module dms_pick (
    input  dms_pkg::fam_masks_t masks,
    input  logic [7:0]          req_mode,
    input  logic                blocked,
    output logic [7:0]          code_o
);
    import dms_pkg::*;

    localparam int NFAM = 3;

    logic [NFAM-1:0]   usable;
    logic [7:0]        fam_mask [NFAM];
    logic [7:0]        fam_base [NFAM];
    family_e           fam_id   [NFAM];
    family_e           winner;
    logic [7:0]        best;

    assign fam_mask[0] = masks.ultra;
    assign fam_mask[1] = masks.multi;
    assign fam_mask[2] = masks.single;
    assign fam_base[0] = BASE_ULTRA;
    assign fam_base[1] = BASE_MULTI;
    assign fam_base[2] = BASE_SINGLE;
    assign fam_id[0] = FAM_ULTRA;
    assign fam_id[1] = FAM_MULTI;
    assign fam_id[2] = FAM_SINGLE;

    for (genvar g = 0; g < NFAM; g++) begin : g_fam
        assign usable[g] = (req_mode >= fam_base[g]) && (|fam_mask[g]);
    end

    // Lowest index = highest priority
    always_comb begin
        winner = FAM_NONE;
        best = '0;
        for (int f = NFAM - 1; f >= 0; f--) begin
            if (usable[f]) begin
                winner = fam_id[f];
                best = fam_base[f] + {5'b0, top_bit(fam_mask[f])};
            end
        end
    end

    always_comb begin
        if (blocked || winner == FAM_NONE) code_o = '0;
        else if (best > req_mode) code_o = req_mode;
        else code_o = best;
    end

endmodule

// File: rtl/dma_mode_sel.sv
module dma_mode_sel #(
    parameter int UDMA_BITS = 8,
    parameter int MW_BITS = 3,
    parameter int SW_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [UDMA_BITS-1:0] host_udma,
    input  logic [MW_BITS-1:0]   host_mwdma,
    input  logic [SW_BITS-1:0]   host_swdma,
    input  logic [UDMA_BITS-1:0] dev_udma,
    input  logic [MW_BITS-1:0]   dev_mwdma,
    input  logic [SW_BITS-1:0]   dev_swdma,
    input  logic [2:0]           id_valid,
    input  logic [7:0]           legacy_t,
    input  logic                 cable80,
    input  logic [7:0]           req_mode,
    input  logic                 is_disk,
    input  logic                 no_pkt_dma,
    output logic                 done,
    output logic [7:0]           mode
);
    import dms_pkg::*;

    fam_masks_t masks;
    logic [7:0] next_code;
    logic       blocked;

    dms_ultra_mask #(.UDMA_BITS(UDMA_BITS)) u_ultra (
        .host_m   (host_udma),
        .dev_m    (dev_udma),
        .valid    (id_valid[VLD_ULTRA]),
        .cable80  (cable80),
        .req_mode (req_mode),
        .mask_o   (masks.ultra)
    );

    dms_regular_mask #(.MW_BITS(MW_BITS), .SW_BITS(SW_BITS)) u_reg (
        .host_mw  (host_mwdma),
        .dev_mw   (dev_mwdma),
        .host_sw  (host_swdma),
        .dev_sw   (dev_swdma),
        .valid    (id_valid[VLD_REGULAR]),
        .legacy_t (legacy_t),
        .mw_o     (masks.multi),
        .sw_o     (masks.single)
    );

    assign blocked = !is_disk && no_pkt_dma;

    dms_pick u_pick (
        .masks    (masks),
        .req_mode (req_mode),
        .blocked  (blocked),
        .code_o   (next_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            mode <= '0;
        end else begin
            done <= start;
            if (start) mode <= next_code;
        end
    end

endmodule

// File: rtl/dms_chk.sv
module dms_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic [7:0] req_mode,
    input logic       is_disk,
    input logic       no_pkt_dma,
    input logic       done,
    input logic [7:0] mode
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (!done && mode == 8'h00));

    // R2
    done_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    // R2
    done_only_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(mode));

    // R9
    ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (mode <= $past(req_mode)));

    // R10
    pkt_block_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !is_disk && no_pkt_dma) |=> (mode == 8'h00));

    // R3
    family_code_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (mode == 8'h00 || mode[7:4] == 4'h4 || mode[7:4] == 4'h2
                   || mode[7:4] == 4'h1 || mode == $past(req_mode)));
endmodule

bind dma_mode_sel dms_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .req_mode   (req_mode),
    .is_disk    (is_disk),
    .no_pkt_dma (no_pkt_dma),
    .done       (done),
    .mode       (mode)
);

// File: tb/dma_mode_sel_tb.sv
module dma_mode_sel_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] host_udma = '0, dev_udma = '0;
    logic [2:0] host_mwdma = '0, dev_mwdma = '0;
    logic [2:0] host_swdma = '0, dev_swdma = '0;
    logic [2:0] id_valid = '0;
    logic [7:0] legacy_t = '0;
    logic       cable80 = 1'b0;
    logic [7:0] req_mode = '0;
    logic       is_disk = 1'b1;
    logic       no_pkt_dma = 1'b0;
    logic       done;
    logic [7:0] mode;

    int applied = 0;
    int failed = 0;

    always #4 clk = ~clk;

    dma_mode_sel u_dut (
        .clk(clk), .rst(rst), .start(start),
        .host_udma(host_udma), .host_mwdma(host_mwdma), .host_swdma(host_swdma),
        .dev_udma(dev_udma), .dev_mwdma(dev_mwdma), .dev_swdma(dev_swdma),
        .id_valid(id_valid), .legacy_t(legacy_t), .cable80(cable80),
        .req_mode(req_mode), .is_disk(is_disk), .no_pkt_dma(no_pkt_dma),
        .done(done), .mode(mode)
    );

    function automatic logic [7:0] hi(input logic [7:0] v);
        logic [7:0] r = 0;
        for (int i = 0; i < 8; i++) if (v[i]) r = 8'(i);
        return r;
    endfunction

    function automatic logic [7:0] expect_mode();
        logic [7:0] um, mw, sw, r;
        um = id_valid[2] ? (host_udma & dev_udma) : 8'h00;
        if (req_mode > 8'h42 && (um & 8'h78) != 0 && !cable80) um = um & 8'h07;
        mw = id_valid[1] ? {5'b0, host_mwdma & dev_mwdma} : 8'h00;
        if (id_valid[1]) sw = {5'b0, host_swdma & dev_swdma};
        else if (legacy_t >= 1 && legacy_t <= 2)
            sw = ((8'd2 << legacy_t) - 8'd1) & {5'b0, host_swdma};
        else sw = 8'h00;
        if (req_mode >= 8'h40 && um != 0) r = 8'h40 + hi(um);
        else if (req_mode >= 8'h20 && mw != 0) r = 8'h20 + hi(mw);
        else if (req_mode >= 8'h10 && sw != 0) r = 8'h10 + hi(sw);
        else r = 8'h00;
        if (r > req_mode) r = req_mode;
        if (!is_disk && no_pkt_dma) r = 8'h00;
        return r;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        applied++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic run(input string req);
        logic [7:0] exp;
        exp = expect_mode();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({req, " done"}, {7'b0, done}, 8'h01);
        check(req, mode, exp);
        @(negedge clk);
        check("R2 done drop", {7'b0, done}, 8'h00);
        check("R2 hold", mode, exp);
    endtask

    task automatic set_all(input logic [7:0] hu, du, input logic [2:0] hm, dm, hs, ds,
                           input logic [2:0] v, input logic [7:0] t, input logic cab,
                           input logic [7:0] rq, input logic dk, np);
        host_udma = hu; dev_udma = du; host_mwdma = hm; dev_mwdma = dm;
        host_swdma = hs; dev_swdma = ds; id_valid = v; legacy_t = t;
        cable80 = cab; req_mode = rq; is_disk = dk; no_pkt_dma = np;
    endtask

    initial begin : watchdog
        #1000000;
        failed++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        check("R1 done", {7'b0, done}, 8'h00);
        check("R1 mode", mode, 8'h00);
        rst = 1'b0;

        // R3 Ultra wins, with cable
        set_all(8'h7F, 8'h7F, 3'h7, 3'h7, 3'h7, 3'h7, 3'b110, 8'd0, 1'b1, 8'h46, 1'b1, 1'b0);
        run("R3 ultra top");
        // R6 no cable, request above 0x42
        cable80 = 1'b0; req_mode = 8'h43;
        run("R6 cable cap");
        // R6 request exactly 0x42: cap not applied, clamp gives 0x42
        req_mode = 8'h42;
        run("R6 boundary");
        // R6 mask without bits 3..6 unaffected
        host_udma = 8'h07; req_mode = 8'h46;
        run("R6 low mask");
        // R5 Ultra validity clear -> multi-word
        host_udma = 8'h7F; id_valid = 3'b010;
        run("R5 ultra invalid");
        // R5 Ultra valid but AND is zero -> fall through
        id_valid = 3'b110; dev_udma = 8'h80; host_udma = 8'h7F;
        run("R5 ultra empty");
        // R4 ceiling below Ultra base skips Ultra
        dev_udma = 8'h7F; req_mode = 8'h30;
        run("R4 skip ultra");
        // R9 clamp inside multi-word
        req_mode = 8'h21;
        run("R9 clamp");
        // R9 below all bases
        req_mode = 8'h0F;
        run("R9 none");
        // R7 regular invalid, legacy 0 -> none
        set_all(8'h00, 8'h00, 3'h7, 3'h7, 3'h7, 3'h7, 3'b000, 8'd0, 1'b1, 8'h46, 1'b1, 1'b0);
        run("R8 legacy zero");
        legacy_t = 8'd2;
        run("R8 legacy two");
        legacy_t = 8'd3;
        run("R8 legacy three");
        legacy_t = 8'd1; host_swdma = 3'h3;
        run("R8 legacy one");
        // R7 single-word from device mask
        set_all(8'h00, 8'h00, 3'h0, 3'h7, 3'h7, 3'h2, 3'b010, 8'd2, 1'b1, 8'h46, 1'b1, 1'b0);
        run("R7 single word");
        // R10 packet device blocked, then allowed
        set_all(8'h7F, 8'h7F, 3'h7, 3'h7, 3'h7, 3'h7, 3'b110, 8'd0, 1'b1, 8'h46, 1'b0, 1'b1);
        run("R10 blocked");
        no_pkt_dma = 1'b0;
        run("R10 allowed");

        for (int n = 0; n < 400; n++) begin
            set_all(8'($urandom), 8'($urandom), 3'($urandom), 3'($urandom),
                    3'($urandom), 3'($urandom), 3'($urandom), 8'($urandom_range(0, 4)),
                    1'($urandom), 8'($urandom_range(0, 8'h48)), 1'($urandom), 1'($urandom));
            run("R3 random");
        end

        // R1 reset clears result
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mode", mode, 8'h00);
        check("R1 reset done", {7'b0, done}, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
        $finish;
    end

endmodule